// File: doc/BRIEF.md
# Clock Source Mode Controller

This block decides where the system clock of a small microcontroller comes from and whether it reaches the rest of the chip. It reads a 2-bit source-select field and a stop request. It also watches a debug-enable input, an oscillator-keep-alive bit, a wake-by-interrupt input and three status inputs: oscillator amplitude good, loss of clock and DCO ready. From these it drives the current operating mode, a gate on the system clock feed, an enable for the external oscillator and a registered select between the internal reference and the external clock.

The analog parts are not in this block: the DCO, the frequency-locked loop and the crystal oscillator. They appear as status inputs and as a one-cycle pulse per external clock edge. An external clock is treated as qualified only after a programmable number of its edges, 4096 by default, have been counted while the oscillator is enabled and reports good amplitude. Reset is the only way back to the default mode without going through the select field. A wake by interrupt keeps the select field and resumes the mode it names.

Top module: `clk_src_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first edge after it, `mode` is 1 (self-clocked), `sys_clk_en` is 1, `osc_en` is 0 and `ref_sel_ext` is 0.
- R2: When the block is running, `stop_req` is 1 and `dbg_en` is 0, `mode` becomes 0 (off) on the next edge and `sys_clk_en` becomes 0. In off, `osc_en` is 0 unless R4 applies.
- R3: When `dbg_en` is 1, `stop_req` has no effect: the mode and the clock feed keep their values.
- R4: In off with `osc_keep` 1, `osc_en` equals `src_sel[1]` and the feed stays gated. Qualification of the external clock is kept, so a wake into the bypassed-external mode enables the feed on the first edge.
- R5: In off, `wake_irq` leaves off on the next edge into the mode named by `src_sel`. While running, `wake_irq` has no effect.
- R6: While running, `src_sel` maps to modes as follows: 00 gives 1 (self-clocked), 01 gives 2 (locked to internal reference), 10 gives 3 (bypassed, external) and 11 gives 4 (locked to external). `osc_en` equals `src_sel[1]`. The mode follows the select on the next edge, so a change from 01 or 11 to 00 gives mode 1.
- R7: In mode 3, `sys_clk_en` is 1 only while the external clock is qualified.
- R8: In mode 4, `ref_sel_ext` is 0 (internal reference) until the external clock is qualified and 1 after.
- R9: The external clock becomes qualified one edge after the QUAL_EDGES-th `ext_edge` pulse counted while `osc_en` and `osc_stable` are 1. Before that it is not qualified. `clk_loss`, or `osc_en` at 0, clears the qualification and the count.
- R10: With `src_sel[1]` = 1, `clk_loss` = 1 and the external clock not qualified, `mode` is 1.
- R11: On a wake with `src_sel[0]` = 1 and `dco_ready` = 0, `mode` stays 1 until `dco_ready` is seen, then takes the mode named by `src_sel`.
- R12: `ref_sel_ext` is a register output and is 1 only in mode 3 or 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 2 | Source-select field |
| stop_req | input | 1 | Request to enter stop |
| dbg_en | input | 1 | Debug enable; keeps clocks running through stop |
| osc_keep | input | 1 | Keep the oscillator running while off |
| wake_irq | input | 1 | Wake from stop by interrupt |
| osc_stable | input | 1 | Oscillator amplitude good |
| clk_loss | input | 1 | Loss of external clock flagged |
| dco_ready | input | 1 | DCO output stable |
| ext_edge | input | 1 | One-cycle pulse per external clock edge |
| mode | output | 3 | Current mode: 0 off, 1 self, 2 int-locked, 3 ext-bypass, 4 ext-locked |
| sys_clk_en | output | 1 | Gate for the system clock feed |
| osc_en | output | 1 | External oscillator enable |
| ref_sel_ext | output | 1 | Clock mux select, 1 = external clock |

## Verification
The bench builds the block with QUAL_EDGES set to 8. This makes the whole qualification window reachable, both the last unqualified edge and the first qualified cycle, and the window is run several times: after a loss of clock, after a stop without keep-alive and after a wake. The bench sweeps all four select codes with the external clock unqualified. It then walks through every entry into and exit from off: with and without debug, with and without keep-alive, and with the DCO ready or not.

// File: rtl/clk_src_pkg.sv
// Package: shared mode encoding for the clock source mode controller.
// Assumes: codes are fixed because software and neighbours decode them.
package clk_src_pkg;

    typedef enum logic [2:0] {
        MODE_OFF      = 3'd0,
        MODE_SELF     = 3'd1,
        MODE_LOCK_INT = 3'd2,
        MODE_BYP_EXT  = 3'd3,
        MODE_LOCK_EXT = 3'd4
    } clk_mode_e;

    localparam int SEL_W = 2;

endpackage

// File: rtl/clk_src_qual.sv
// Module: external clock qualifier. Counts external edge pulses while the
// oscillator is enabled and reports good amplitude; flags the clock as
// qualified after QUAL_EDGES of them.
// Assumes: ext_edge is already synchronous, one cycle per edge; QUAL_EDGES >= 2.
module clk_src_qual #(
    parameter int QUAL_EDGES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_on,
    input  logic osc_stable,
    input  logic clk_loss,
    input  logic ext_edge,
    output logic ext_ok
);

    localparam int CNT_W = (QUAL_EDGES > 2) ? $clog2(QUAL_EDGES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_EDGES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             ok_q;
    logic             clear;
    logic             count_en;

    assign clear    = clk_loss || !osc_on;
    assign count_en = osc_stable && ext_edge && !ok_q;

    // Edge counter and qualified flag; loss or oscillator off restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
            ok_q  <= 1'b0;
        end else if (count_en) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
                ok_q <= 1'b1;
            end
        end
    end

    assign ext_ok = ok_q;

endmodule

// File: rtl/clk_src_seq.sv
// Module: stop/wake sequencer and mode decoder. Tracks whether the block is
// off and whether it waits for the DCO after a wake, and computes the mode
// for the next cycle.
// Assumes: the outputs are registered by the caller.
module clk_src_seq
    import clk_src_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             stop_req,
    input  logic             dbg_en,
    input  logic             wake_irq,
    input  logic             dco_ready,
    input  logic             clk_loss,
    input  logic             ext_ok,
    output logic             off_nxt,
    output clk_mode_e        mode_nxt
);

    logic      off_q;
    logic      wait_q;
    logic      wait_nxt;
    clk_mode_e sel_mode;

    // Next off/wait state from stop, debug, wake and DCO status.
    always_comb begin
        off_nxt  = off_q;
        wait_nxt = wait_q;
        if (off_q) begin
            if (wake_irq) begin
                off_nxt  = 1'b0;
                wait_nxt = src_sel[0] && !dco_ready;
            end
        end else if (stop_req && !dbg_en) begin
            off_nxt  = 1'b1;
            wait_nxt = 1'b0;
        end else if (wait_q && dco_ready) begin
            wait_nxt = 1'b0;
        end
    end

    // Mode named by the select field, with fallback on a lost external clock.
    always_comb begin
        unique case (src_sel)
            2'b00:   sel_mode = MODE_SELF;
            2'b01:   sel_mode = MODE_LOCK_INT;
            2'b10:   sel_mode = MODE_BYP_EXT;
            default: sel_mode = MODE_LOCK_EXT;
        endcase
        if (src_sel[1] && clk_loss && !ext_ok) begin
            sel_mode = MODE_SELF;
        end
    end

    // Final next mode: off wins, then the DCO wait, then the select.
    always_comb begin
        if (off_nxt) begin
            mode_nxt = MODE_OFF;
        end else if (wait_nxt) begin
            mode_nxt = MODE_SELF;
        end else begin
            mode_nxt = sel_mode;
        end
    end

    // Sequencer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q  <= 1'b0;
            wait_q <= 1'b0;
        end else begin
            off_q  <= off_nxt;
            wait_q <= wait_nxt;
        end
    end

endmodule

// File: rtl/clk_src_outreg.sv
// Module: registered outputs. Turns the next mode into the mode register,
// the feed gate, the oscillator enable and the glitch-free mux select.
// Assumes: every output changes only on a clock edge.
module clk_src_outreg
    import clk_src_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  clk_mode_e mode_nxt,
    input  logic      off_nxt,
    input  logic      want_ext,
    input  logic      osc_keep,
    input  logic      ext_ok,
    output clk_mode_e mode_q,
    output logic      feed_q,
    output logic      osc_q,
    output logic      ext_sel_q
);

    logic ext_mode;
    logic feed_nxt;
    logic osc_nxt;
    logic sel_nxt;

    // Decode what the next mode means for each output.
    always_comb begin
        ext_mode = (mode_nxt == MODE_BYP_EXT) || (mode_nxt == MODE_LOCK_EXT);
        sel_nxt  = ext_mode && ext_ok;
        osc_nxt  = want_ext && (!off_nxt || osc_keep);
        if (mode_nxt == MODE_OFF) begin
            feed_nxt = 1'b0;
        end else if (mode_nxt == MODE_BYP_EXT) begin
            feed_nxt = ext_ok;
        end else begin
            feed_nxt = 1'b1;
        end
    end

    // Output registers with reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_SELF;
            feed_q    <= 1'b1;
            osc_q     <= 1'b0;
            ext_sel_q <= 1'b0;
        end else begin
            mode_q    <= mode_nxt;
            feed_q    <= feed_nxt;
            osc_q     <= osc_nxt;
            ext_sel_q <= sel_nxt;
        end
    end

endmodule

// File: rtl/clk_src_ctrl.sv
// Module: top of the clock source mode controller. Wires the qualifier,
// the sequencer and the output registers together.
// Assumes: all inputs are synchronous to clk.
module clk_src_ctrl
    import clk_src_pkg::*;
#(
    parameter int QUAL_EDGES = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       stop_req,
    input  logic       dbg_en,
    input  logic       osc_keep,
    input  logic       wake_irq,
    input  logic       osc_stable,
    input  logic       clk_loss,
    input  logic       dco_ready,
    input  logic       ext_edge,
    output logic [2:0] mode,
    output logic       sys_clk_en,
    output logic       osc_en,
    output logic       ref_sel_ext
);

    logic      ext_ok;
    logic      off_nxt;
    clk_mode_e mode_nxt;
    clk_mode_e mode_q;
    logic      osc_q;

    clk_src_qual #(
        .QUAL_EDGES(QUAL_EDGES)
    ) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_on    (osc_q),
        .osc_stable(osc_stable),
        .clk_loss  (clk_loss),
        .ext_edge  (ext_edge),
        .ext_ok    (ext_ok)
    );

    clk_src_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sel  (src_sel),
        .stop_req (stop_req),
        .dbg_en   (dbg_en),
        .wake_irq (wake_irq),
        .dco_ready(dco_ready),
        .clk_loss (clk_loss),
        .ext_ok   (ext_ok),
        .off_nxt  (off_nxt),
        .mode_nxt (mode_nxt)
    );

    clk_src_outreg u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_nxt (mode_nxt),
        .off_nxt  (off_nxt),
        .want_ext (src_sel[1]),
        .osc_keep (osc_keep),
        .ext_ok   (ext_ok),
        .mode_q   (mode_q),
        .feed_q   (sys_clk_en),
        .osc_q    (osc_q),
        .ext_sel_q(ref_sel_ext)
    );

    assign mode   = mode_q;
    assign osc_en = osc_q;

endmodule

// File: rtl/clk_src_ctrl_chk.sv
// Module: property checker for clk_src_ctrl, attached with bind below.
// Assumes: it only observes the top-level ports.
module clk_src_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_req,
    input logic       dbg_en,
    input logic       wake_irq,
    input logic [1:0] src_sel,
    input logic [2:0] mode,
    input logic       sys_clk_en,
    input logic       ref_sel_ext
);

    a_r2_stop_enters_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 3'd0 && stop_req && !dbg_en) |=> (mode == 3'd0));

    a_r2_off_gates_feed: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0) |-> !sys_clk_en);

    a_r3_debug_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 3'd0 && dbg_en) |=> (mode != 3'd0));

    a_r5_wake_leaves_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 && wake_irq) |=> (mode != 3'd0));

    a_r7_bypass_feed_matches_mux: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3) |-> (sys_clk_en == ref_sel_ext));

    a_r12_ext_select_only_ext_modes: assert property (@(posedge clk) disable iff (!rst_n)
        ref_sel_ext |-> (mode == 3'd3 || mode == 3'd4));

    a_r6_self_on_zero_select: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 3'd0 && src_sel == 2'b00 && !stop_req && !wake_irq) |=> (mode == 3'd1));

endmodule

bind clk_src_ctrl clk_src_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_req   (stop_req),
    .dbg_en     (dbg_en),
    .wake_irq   (wake_irq),
    .src_sel    (src_sel),
    .mode       (mode),
    .sys_clk_en (sys_clk_en),
    .ref_sel_ext(ref_sel_ext)
);

// File: tb/clk_src_ctrl_tb.sv
// Bench: directed sweep of clk_src_ctrl with a short qualification window.
module clk_src_ctrl_tb;

    localparam int QN = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] src_sel;
    logic       stop_req, dbg_en, osc_keep, wake_irq;
    logic       osc_stable, clk_loss, dco_ready, ext_edge;
    logic [2:0] mode;
    logic       sys_clk_en, osc_en, ref_sel_ext;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    clk_src_ctrl #(.QUAL_EDGES(QN)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .stop_req(stop_req),
        .dbg_en(dbg_en), .osc_keep(osc_keep), .wake_irq(wake_irq),
        .osc_stable(osc_stable), .clk_loss(clk_loss), .dco_ready(dco_ready),
        .ext_edge(ext_edge), .mode(mode), .sys_clk_en(sys_clk_en),
        .osc_en(osc_en), .ref_sel_ext(ref_sel_ext)
    );

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input int m, input int f, input int o, input int r);
        chk(req, "mode", int'(mode), m);
        chk(req, "sys_clk_en", int'(sys_clk_en), f);
        chk(req, "osc_en", int'(osc_en), o);
        chk(req, "ref_sel_ext", int'(ref_sel_ext), r);
    endtask

    // Hold ext_edge high for n cycles.
    task automatic edges(input int n);
        ext_edge = 1'b1;
        step(n);
        ext_edge = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; src_sel = 2'b00; stop_req = 0; dbg_en = 0; osc_keep = 0;
        wake_irq = 0; osc_stable = 0; clk_loss = 0; dco_ready = 1; ext_edge = 0;
        @(negedge clk);
        step(3);
        chk_all("R1", 1, 1, 0, 0);
        rst_n = 1'b1;
        step(1);
        chk_all("R1", 1, 1, 0, 0);

        // R6: every select code with the external clock unqualified.
        for (int s = 0; s < 4; s++) begin
            src_sel = 2'(s);
            step(1);
            chk_all("R6", s + 1, (s == 2) ? 0 : 1, s / 2, 0);
        end
        src_sel = 2'b00;
        step(1);
        chk("R6", "mode after 11->00", int'(mode), 1);

        // R9/R7: qualification window in bypassed-external mode.
        src_sel = 2'b10;
        step(1);
        osc_stable = 1'b1;
        edges(QN - 1);
        chk_all("R9", 3, 0, 1, 0);
        edges(1);
        chk("R9", "feed one edge after last pulse", int'(sys_clk_en), 0);
        step(1);
        chk_all("R7", 3, 1, 1, 1);

        // R8: locked-external with a qualified clock selects external.
        src_sel = 2'b11;
        step(1);
        chk_all("R8", 4, 1, 1, 1);

        // R3: debug keeps the clock through a stop request.
        dbg_en = 1'b1; stop_req = 1'b1;
        step(2);
        chk_all("R3", 4, 1, 1, 1);
        dbg_en = 1'b0;
        step(1);
        chk_all("R2", 0, 0, 0, 0);
        stop_req = 1'b0;
        step(2);
        chk("R5", "off holds without wake", int'(mode), 0);

        // R11: wake with DCO not ready holds self-clocked.
        dco_ready = 1'b0; wake_irq = 1'b1;
        step(1);
        wake_irq = 1'b0;
        chk_all("R11", 1, 1, 1, 0);
        step(1);
        chk("R11", "still waiting", int'(mode), 1);
        dco_ready = 1'b1;
        step(1);
        chk_all("R8", 4, 1, 1, 0);
        edges(QN);
        step(1);
        chk_all("R8", 4, 1, 1, 1);

        // R10: loss of clock in an external mode falls back.
        src_sel = 2'b10;
        step(1);
        chk_all("R7", 3, 1, 1, 1);
        clk_loss = 1'b1;
        step(2);
        chk_all("R10", 1, 1, 1, 0);
        clk_loss = 1'b0;
        step(1);
        chk_all("R7", 3, 0, 1, 0);

        // R4: keep-alive through off preserves qualification.
        edges(QN);
        step(1);
        chk("R4", "qualified before stop", int'(sys_clk_en), 1);
        osc_keep = 1'b1; stop_req = 1'b1;
        step(1);
        stop_req = 1'b0;
        chk_all("R4", 0, 0, 1, 0);
        step(3);
        chk("R4", "oscillator kept", int'(osc_en), 1);
        wake_irq = 1'b1;
        step(1);
        chk_all("R4", 3, 1, 1, 1);
        step(1);
        chk("R5", "wake while running", int'(mode), 3);
        wake_irq = 1'b0; osc_keep = 1'b0;

        // R2/R11: internal-locked stop and wake with DCO ready.
        src_sel = 2'b01;
        step(1);
        chk_all("R6", 2, 1, 0, 0);
        stop_req = 1'b1;
        step(1);
        stop_req = 1'b0;
        chk_all("R2", 0, 0, 0, 0);
        wake_irq = 1'b1;
        step(1);
        wake_irq = 1'b0;
        chk_all("R11", 2, 1, 0, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule